// File: doc/BRIEF.md
# BCH Error Location Applier

This block owns the buffer for one 512-byte sector and the ECC bytes stored with it. A host loads the sector and its stored ECC through a byte write port, and loads the ECC bytes computed for the sector through a second small port. An external error locator gets those computed bytes through an output stream in reverse byte order. It then returns a list of bit locations. The block applies those locations to the buffer, flips the indicated bits in place, and reports how many locations it accepted and whether any of them fell outside the codeword. The host then reads the corrected sector back through the read port.

Two strengths are supported, chosen by `mode16` when a session starts. The 8-bit strength mode uses 13 computed ECC bytes and stores 14, and the last stored byte is reserved. The 16-bit strength mode uses and stores 26 bytes. A location counts bits backward from the end of the codeword, so bit 0 is the lowest bit of the last byte in the span. A sector whose computed ECC is all zero is clean. A sector whose stored ECC is all 0xFF is erased. Both are passed untouched, and the location list is drained and discarded.

Top module: `bch_loc_fixer`

## Requirements
- R1: Buffer addresses 0..511 hold sector data and 512..537 hold stored ECC byte (address − 512). `rd_data` shows the byte at `rd_addr` one clock after the address is sampled. Host writes are ignored while a session is active.
- R2: A `start` pulse while idle latches `mode16` for the session. With 0, the codeword span is 525 bytes. With 1, the span is 538 bytes.
- R3: If computed ECC bytes 0..12 (8-bit mode) or 0..25 (16-bit mode) are all zero when the session starts, nothing in the buffer changes. The list is consumed and the result is count 0 with no error.
- R4: If stored ECC bytes 0..13 (8-bit mode) or 0..25 (16-bit mode) are all 0xFF when the session starts, nothing in the buffer changes. The list is consumed and the result is count 0 with no error. A non-0xFF byte 13 prevents this in 8-bit mode.
- R5: A location L gives byte position span − 1 − (L div 8) and bit (L mod 8). A position below 512 flips that bit of the data byte.
- R6: A position from 512 to span − 1 flips bit (L mod 8) of stored ECC byte (position − 512). In 8-bit mode, ECC byte 13 is never altered.
- R7: If (L div 8) ≥ span, the location is invalid. No byte changes, the error flag is set for the session, and the following locations are still applied.
- R8: During a session, `loc_ready` is high and one location is accepted per clock. `done` pulses for one clock, one clock after the handshake that carries `loc_last`. `result_cnt` then gives the number of locations accepted and `result_err` gives the error flag. Both hold until the next result.
- R9: A session accepts at most 16 locations. The 16th location ends the session even if `loc_last` is low.
- R10: A `rev_start` pulse streams the computed ECC bytes from the highest index down to index 0: 13 bytes in 8-bit mode, 26 bytes in 16-bit mode. `rev_last` marks index 0. Data holds while `rev_valid` is high and `rev_ready` is low.
- R11: After reset, `done`, `loc_ready`, `rev_valid`, `result_cnt` and `result_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode16 | input | 1 | Strength select: 0 = 8-bit, 1 = 16-bit |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 10 | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| rd_addr | input | 10 | Buffer read address |
| rd_data | output | 8 | Registered read byte |
| calc_we | input | 1 | Computed-ECC byte write strobe |
| calc_idx | input | 5 | Computed-ECC byte index |
| calc_data | input | 8 | Computed-ECC byte value |
| start | input | 1 | Begin a correction session |
| loc_valid | input | 1 | Location valid |
| loc_ready | output | 1 | Location accepted when valid |
| loc_bits | input | 13 | Error bit location L |
| loc_last | input | 1 | Final location of the list |
| done | output | 1 | One-clock result strobe |
| result_cnt | output | 5 | Number of locations accepted |
| result_err | output | 1 | An invalid location was seen |
| rev_start | input | 1 | Begin reversed computed-ECC stream |
| rev_valid | output | 1 | Stream byte valid |
| rev_ready | input | 1 | Stream byte taken |
| rev_data | output | 8 | Stream byte |
| rev_last | output | 1 | Final stream byte |

## Verification
Random sessions in both modes mix in-span locations, out-of-span locations and repeated locations. Repeated locations show that a bit flipped twice is restored. The whole buffer is read back each time, which separates data flips from ECC flips. Directed sessions place locations at the exact span edges: L = 0, the last ECC bit, the first data bit, the last data bit, and the first invalid value. These separate the 525-byte and 538-byte spans and catch off-by-one errors. Other sessions use all-zero computed ECC, all-0xFF stored ECC, and all-0xFF except byte 13. These tell the clean screen and the erased screen apart, and check that the erased screen looks at 14 stored bytes rather than 13. A 16-entry list without a last marker, and a stream drained under random back-pressure, cover the list cap and the reversed byte order.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
    typedef enum logic [1:0] {
        FX_IDLE  = 2'd0,
        FX_RUN   = 2'd1,
        FX_DRAIN = 2'd2
    } fx_state_e;
endpackage

// File: rtl/bchfix_locmap.sv
module bchfix_locmap #(
    parameter int DATA_BYTES = 512,
    parameter int ECC_MAX    = 26,
    parameter int ECC_USED8  = 13,
    parameter int LOC_W      = 13,
    parameter int ADDR_W     = 10
) (
    input  logic              mode16,
    input  logic [LOC_W-1:0]  loc,
    output logic              bad,
    output logic              hit_data,
    output logic              hit_ecc,
    output logic [ADDR_W-1:0] pos,
    output logic [2:0]        bit_sel
);
    localparam int SPAN8  = DATA_BYTES + ECC_USED8;
    localparam int SPAN16 = DATA_BYTES + ECC_MAX;
    localparam int CW     = LOC_W + 1;

    logic [CW-1:0] span_w;
    logic [CW-1:0] quot_w;
    logic [CW-1:0] pos_w;

    always_comb begin
        span_w   = mode16 ? CW'(SPAN16) : CW'(SPAN8);
        quot_w   = CW'(loc >> 3);
        bad      = (quot_w >= span_w);
        pos_w    = span_w - CW'(1) - quot_w;
        hit_data = !bad && (pos_w < CW'(DATA_BYTES));
        hit_ecc  = !bad && !hit_data;
        pos      = pos_w[ADDR_W-1:0];
        bit_sel  = loc[2:0];
    end
endmodule

// File: rtl/bchfix_screen.sv
module bchfix_screen #(
    parameter int ECC_MAX    = 26,
    parameter int ECC_USED8  = 13,
    parameter int ECC_STORE8 = 14
) (
    input  logic                      mode16,
    input  logic [ECC_MAX-1:0][7:0]   calc,
    input  logic [ECC_MAX-1:0][7:0]   stored,
    output logic                      clean,
    output logic                      erased
);
    logic [ECC_MAX-1:0] calc_ok;
    logic [ECC_MAX-1:0] store_ok;

    for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
        if (i < ECC_USED8) begin : g_c8
            assign calc_ok[i] = (calc[i] == 8'h00);
        end else begin : g_c16
            assign calc_ok[i] = (calc[i] == 8'h00) || !mode16;
        end
        if (i < ECC_STORE8) begin : g_s8
            assign store_ok[i] = (stored[i] == 8'hFF);
        end else begin : g_s16
            assign store_ok[i] = (stored[i] == 8'hFF) || !mode16;
        end
    end

    assign clean  = &calc_ok;
    assign erased = &store_ok;
endmodule

// File: rtl/bchfix_revout.sv
module bchfix_revout #(
    parameter int ECC_MAX   = 26,
    parameter int ECC_USED8 = 13,
    localparam int IDX_W    = $clog2(ECC_MAX)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode16,
    input  logic                    start,
    input  logic [ECC_MAX-1:0][7:0] calc,
    input  logic                    ready,
    output logic                    valid,
    output logic [7:0]              data,
    output logic                    last
);
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } rv_t;

    rv_t rv_d, rv_q;

    always_comb begin
        rv_d = rv_q;
        if (!rv_q.active) begin
            if (start) begin
                rv_d.active = 1'b1;
                rv_d.idx    = mode16 ? IDX_W'(ECC_MAX - 1) : IDX_W'(ECC_USED8 - 1);
            end
        end else if (ready) begin
            if (rv_q.idx == '0) rv_d.active = 1'b0;
            else                rv_d.idx    = rv_q.idx - IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv_q <= '0;
        else        rv_q <= rv_d;
    end

    assign valid = rv_q.active;
    assign data  = calc[rv_q.idx];
    assign last  = rv_q.active && (rv_q.idx == '0);
endmodule

// File: rtl/bch_loc_fixer.sv
module bch_loc_fixer #(
    parameter int DATA_BYTES = 512,
    parameter int ECC_MAX    = 26,
    parameter int ECC_USED8  = 13,
    parameter int ECC_STORE8 = 14,
    parameter int MAX_LOCS   = 16,
    localparam int TOTAL     = DATA_BYTES + ECC_MAX,
    localparam int ADDR_W    = $clog2(TOTAL),
    localparam int DADDR_W   = $clog2(DATA_BYTES),
    localparam int EIDX_W    = $clog2(ECC_MAX),
    localparam int LOC_W     = $clog2(8 * TOTAL),
    localparam int CNT_W     = $clog2(MAX_LOCS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode16,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              calc_we,
    input  logic [EIDX_W-1:0] calc_idx,
    input  logic [7:0]        calc_data,
    input  logic              start,
    input  logic              loc_valid,
    output logic              loc_ready,
    input  logic [LOC_W-1:0]  loc_bits,
    input  logic              loc_last,
    output logic              done,
    output logic [CNT_W-1:0]  result_cnt,
    output logic              result_err,
    input  logic              rev_start,
    output logic              rev_valid,
    input  logic              rev_ready,
    output logic [7:0]        rev_data,
    output logic              rev_last
);
    import bchfix_pkg::*;

    typedef struct packed {
        fx_state_e        st;
        logic             mode16;
        logic [CNT_W-1:0] cnt;
        logic             err;
        logic             done;
        logic [CNT_W-1:0] res_cnt;
        logic             res_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [7:0]              data_mem [DATA_BYTES];
    logic [ECC_MAX-1:0][7:0] ecc_q;
    logic [ECC_MAX-1:0][7:0] calc_q;
    logic [7:0]              rd_q;

    logic              loc_bad, loc_hit_d, loc_hit_e;
    logic [ADDR_W-1:0] loc_pos;
    logic [2:0]        loc_bit;
    logic              scr_clean, scr_erased;

    logic              host_ok;
    logic              fix_data_we, fix_ecc_we;
    logic [7:0]        fix_mask;
    logic [ADDR_W-1:0] fix_eoff, wr_eoff, rd_eoff;
    logic              accept;

    bchfix_locmap #(
        .DATA_BYTES(DATA_BYTES), .ECC_MAX(ECC_MAX), .ECC_USED8(ECC_USED8),
        .LOC_W(LOC_W), .ADDR_W(ADDR_W)
    ) i_locmap (
        .mode16  (ctl_q.mode16),
        .loc     (loc_bits),
        .bad     (loc_bad),
        .hit_data(loc_hit_d),
        .hit_ecc (loc_hit_e),
        .pos     (loc_pos),
        .bit_sel (loc_bit)
    );

    bchfix_screen #(
        .ECC_MAX(ECC_MAX), .ECC_USED8(ECC_USED8), .ECC_STORE8(ECC_STORE8)
    ) i_screen (
        .mode16(mode16),
        .calc  (calc_q),
        .stored(ecc_q),
        .clean (scr_clean),
        .erased(scr_erased)
    );

    bchfix_revout #(
        .ECC_MAX(ECC_MAX), .ECC_USED8(ECC_USED8)
    ) i_revout (
        .clk   (clk),
        .rst_n (rst_n),
        .mode16(mode16),
        .start (rev_start),
        .calc  (calc_q),
        .ready (rev_ready),
        .valid (rev_valid),
        .data  (rev_data),
        .last  (rev_last)
    );

    // session control: next state
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        accept      = (ctl_q.st != FX_IDLE) && loc_valid;
        fix_data_we = 1'b0;
        fix_ecc_we  = 1'b0;
        case (ctl_q.st)
            FX_IDLE: begin
                if (start) begin
                    ctl_d.mode16 = mode16;
                    ctl_d.cnt    = '0;
                    ctl_d.err    = 1'b0;
                    ctl_d.st     = (scr_clean || scr_erased) ? FX_DRAIN : FX_RUN;
                end
            end
            FX_RUN, FX_DRAIN: begin
                if (accept) begin
                    if (ctl_q.st == FX_RUN) begin
                        fix_data_we = loc_hit_d;
                        fix_ecc_we  = loc_hit_e;
                        ctl_d.err   = ctl_q.err | loc_bad;
                    end
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (loc_last || (ctl_q.cnt == CNT_W'(MAX_LOCS - 1))) begin
                        ctl_d.st      = FX_IDLE;
                        ctl_d.done    = 1'b1;
                        ctl_d.res_cnt = (ctl_q.st == FX_RUN) ? ctl_q.cnt + CNT_W'(1) : '0;
                        ctl_d.res_err = (ctl_q.st == FX_RUN) ? (ctl_q.err | loc_bad) : 1'b0;
                    end
                end
            end
            default: ctl_d.st = FX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= FX_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_ok  = (ctl_q.st == FX_IDLE);
    assign fix_mask = 8'(1) << loc_bit;
    assign fix_eoff = loc_pos - ADDR_W'(DATA_BYTES);
    assign wr_eoff  = wr_addr - ADDR_W'(DATA_BYTES);
    assign rd_eoff  = rd_addr - ADDR_W'(DATA_BYTES);

    // sector data: host fill or single-cycle read-modify-write flip
    always_ff @(posedge clk) begin
        if (host_ok && wr_en && (wr_addr < ADDR_W'(DATA_BYTES)))
            data_mem[wr_addr[DADDR_W-1:0]] <= wr_data;
        else if (fix_data_we)
            data_mem[loc_pos[DADDR_W-1:0]] <= data_mem[loc_pos[DADDR_W-1:0]] ^ fix_mask;
    end

    // stored ECC bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecc_q <= '0;
        end else if (host_ok && wr_en && (wr_addr >= ADDR_W'(DATA_BYTES))
                     && (wr_addr < ADDR_W'(TOTAL))) begin
            ecc_q[wr_eoff[EIDX_W-1:0]] <= wr_data;
        end else if (fix_ecc_we) begin
            ecc_q[fix_eoff[EIDX_W-1:0]] <= ecc_q[fix_eoff[EIDX_W-1:0]] ^ fix_mask;
        end
    end

    // computed ECC bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calc_q <= '0;
        end else if (host_ok && calc_we && (calc_idx < EIDX_W'(ECC_MAX))) begin
            calc_q[calc_idx] <= calc_data;
        end
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_addr < ADDR_W'(DATA_BYTES))
            rd_q <= data_mem[rd_addr[DADDR_W-1:0]];
        else if (rd_addr < ADDR_W'(TOTAL))
            rd_q <= ecc_q[rd_eoff[EIDX_W-1:0]];
        else
            rd_q <= '0;
    end

    assign rd_data    = rd_q;
    assign loc_ready  = (ctl_q.st != FX_IDLE);
    assign done       = ctl_q.done;
    assign result_cnt = ctl_q.res_cnt;
    assign result_err = ctl_q.res_err;
endmodule

// File: rtl/bchfix_chk.sv
module bchfix_chk #(
    parameter int CNT_W    = 5,
    parameter int MAX_LOCS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [CNT_W-1:0] result_cnt,
    input logic             result_err,
    input logic             loc_ready,
    input logic             rev_valid,
    input logic             rev_ready,
    input logic [7:0]       rev_data,
    input logic             rev_last
);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !loc_ready);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(result_cnt) && $stable(result_err))));

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result_cnt <= CNT_W'(MAX_LOCS)));

    a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rev_last |-> rev_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_valid && !rev_ready) |=> (rev_valid && $stable(rev_data) && $stable(rev_last)));
endmodule

bind bch_loc_fixer bchfix_chk #(.CNT_W(CNT_W), .MAX_LOCS(MAX_LOCS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .result_cnt(result_cnt),
    .result_err(result_err),
    .loc_ready (loc_ready),
    .rev_valid (rev_valid),
    .rev_ready (rev_ready),
    .rev_data  (rev_data),
    .rev_last  (rev_last)
);

// File: tb/test_bch_loc_fixer.sv
module test_bch_loc_fixer;
    localparam int CLK_NS   = 10;
    localparam int DBYTES   = 512;
    localparam int EMAX     = 26;
    localparam int TOTAL    = DBYTES + EMAX;
    localparam int WDOG     = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode16 = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [9:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        calc_we = 1'b0;
    logic [4:0]  calc_idx = '0;
    logic [7:0]  calc_data = '0;
    logic        start = 1'b0;
    logic        loc_valid = 1'b0;
    logic        loc_ready;
    logic [12:0] loc_bits = '0;
    logic        loc_last = 1'b0;
    logic        done;
    logic [4:0]  result_cnt;
    logic        result_err;
    logic        rev_start = 1'b0;
    logic        rev_valid;
    logic        rev_ready = 1'b0;
    logic [7:0]  rev_data;
    logic        rev_last;

    bch_loc_fixer i_bch_loc_fixer (.*);

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] ref_mem [TOTAL];
    logic [7:0] ref_calc [EMAX];
    int locs [16];

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cycles, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int span_of(input bit m16);
        return m16 ? TOTAL : DBYTES + 13;
    endfunction

    task automatic load_all();
        for (int a = 0; a < TOTAL; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 10'(a); wr_data = ref_mem[a];
        end
        for (int c = 0; c < EMAX; c++) begin
            @(negedge clk);
            wr_en = 1'b0; calc_we = 1'b1; calc_idx = 5'(c); calc_data = ref_calc[c];
        end
        @(negedge clk);
        wr_en = 1'b0; calc_we = 1'b0;
    endtask

    task automatic readback(input string req);
        @(negedge clk);
        rd_addr = 10'd0;
        for (int a = 0; a < TOTAL; a++) begin
            @(negedge clk);
            chk(req, int'(rd_data), int'(ref_mem[a]));
            rd_addr = 10'(a + 1);
        end
    endtask

    task automatic randomize_ref(input int kind);
        for (int a = 0; a < TOTAL; a++) ref_mem[a] = 8'($urandom);
        for (int c = 0; c < EMAX; c++) ref_calc[c] = 8'($urandom) | 8'h01;
        if (kind == 1) for (int c = 0; c < EMAX; c++) ref_calc[c] = 8'h00;
        if (kind == 2) for (int a = DBYTES; a < TOTAL; a++) ref_mem[a] = 8'hFF;
    endtask

    // runs one session over locs[0..n-1] and checks result
    task automatic session(input bit m16, input int n, input bit use_last, input string req);
        int  sp, ncalc, nstore, q, p, ecnt;
        bit  clean, erased, eerr;
        logic [7:0] keep0;
        sp = span_of(m16);
        ncalc = m16 ? 26 : 13;
        nstore = m16 ? 26 : 14;
        clean = 1; erased = 1;
        for (int c = 0; c < ncalc; c++) if (ref_calc[c] != 8'h00) clean = 0;
        for (int c = 0; c < nstore; c++) if (ref_mem[DBYTES + c] != 8'hFF) erased = 0;
        eerr = 0; ecnt = 0;
        if (!clean && !erased) begin
            ecnt = n;
            for (int k = 0; k < n; k++) begin
                q = locs[k] / 8;
                if (q >= sp) eerr = 1;
                else begin
                    p = sp - 1 - q;
                    ref_mem[p] = ref_mem[p] ^ (8'(1) << (locs[k] % 8));
                end
            end
        end
        keep0 = ref_mem[0];
        @(negedge clk);
        mode16 = m16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if ($urandom % 4 == 0) begin
                loc_valid = 1'b0;
                @(negedge clk);
            end
            chk("R8 ready in session", int'(loc_ready), 1);
            loc_valid = 1'b1; loc_bits = 13'(locs[k]);
            loc_last = use_last && (k == n - 1);
            if (k == 0) begin
                wr_en = 1'b1; wr_addr = 10'd0; wr_data = ~keep0;  // R1 write ignored
            end
            @(negedge clk);
            wr_en = 1'b0;
            if (k != n - 1) chk("R8 no early done", int'(done), 0);
        end
        loc_valid = 1'b0; loc_last = 1'b0;
        chk({req, " done"}, int'(done), 1);
        chk({req, " count"}, int'(result_cnt), ecnt);
        chk({req, " error"}, int'(result_err), int'(eerr));
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        chk("R8 result hold", int'(result_cnt), ecnt);
        chk("R8 ready low after", int'(loc_ready), 0);
        readback({req, " buffer"});
    endtask

    task automatic rev_test(input bit m16);
        int nb, k, guard;
        nb = m16 ? 26 : 13;
        @(negedge clk);
        mode16 = m16; rev_start = 1'b1;
        @(negedge clk);
        rev_start = 1'b0;
        chk("R10 valid after start", int'(rev_valid), 1);
        k = 0; guard = 0;
        while (k < nb && guard < 500) begin
            rev_ready = ($urandom % 3) != 0;
            if (rev_valid && rev_ready) begin
                chk("R10 reversed byte", int'(rev_data), int'(ref_calc[nb - 1 - k]));
                chk("R10 last flag", int'(rev_last), int'(k == nb - 1));
                k++;
            end
            guard++;
            @(negedge clk);
        end
        rev_ready = 1'b0;
        chk("R10 stream length", k, nb);
        chk("R10 stream ends", int'(rev_valid), 0);
    endtask

    initial begin
        int sp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 done", int'(done), 0);
        chk("R11 ready", int'(loc_ready), 0);
        chk("R11 rev_valid", int'(rev_valid), 0);
        chk("R11 count", int'(result_cnt), 0);
        chk("R11 error", int'(result_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 fill and readback
        randomize_ref(0); load_all(); readback("R1 fill");

        // R5 R6 R7 edges in 8-bit mode (span 525)
        locs[0] = 0; locs[1] = 103; locs[2] = 104; locs[3] = 4199; locs[4] = 4200; locs[5] = 110;
        session(1'b0, 6, 1'b1, "R2 R5 R6 R7 edge8");
        // R5 R6 R7 edges in 16-bit mode (span 538)
        randomize_ref(0); load_all();
        locs[0] = 0; locs[1] = 207; locs[2] = 208; locs[3] = 4303; locs[4] = 4304; locs[5] = 4200;
        session(1'b1, 6, 1'b1, "R2 R5 R6 R7 edge16");

        // R3 clean, with an invalid location in the list
        randomize_ref(1); load_all();
        locs[0] = 40; locs[1] = 8000; locs[2] = 3000;
        session(1'b0, 3, 1'b1, "R3 clean");
        // R4 erased in both modes
        randomize_ref(2); load_all();
        locs[0] = 9; locs[1] = 1200;
        session(1'b1, 2, 1'b1, "R4 erased16");
        randomize_ref(2); load_all();
        session(1'b0, 2, 1'b1, "R4 erased8");
        // R4: byte 13 not 0xFF in 8-bit mode -> corrections happen
        randomize_ref(2); ref_mem[DBYTES + 13] = 8'h7E; load_all();
        locs[0] = 0; locs[1] = 500;
        session(1'b0, 2, 1'b1, "R4 R6 byte13");

        // R9 sixteen locations without last
        randomize_ref(0); load_all();
        for (int k = 0; k < 16; k++) locs[k] = int'($urandom % 4200);
        session(1'b0, 16, 1'b0, "R9 cap");

        // random sessions
        for (int s = 0; s < 24; s++) begin
            bit m;
            int n, r;
            m = 1'($urandom);
            sp = span_of(m);
            r = int'($urandom % 10);
            randomize_ref(r == 0 ? 1 : (r == 1 ? 2 : 0));
            load_all();
            n = 1 + int'($urandom % 16);
            for (int k = 0; k < n; k++) begin
                int t;
                t = int'($urandom % 10);
                if (t < 7)       locs[k] = int'($urandom % (sp * 8));
                else if (t == 7) locs[k] = sp * 8 + int'($urandom % (8192 - sp * 8));
                else if (t == 8) locs[k] = int'($urandom % 216);
                else             locs[k] = (k > 0) ? locs[k - 1] : 5;
            end
            session(m, n, (n < 16) ? 1'b1 : 1'($urandom), "R5 R6 R7 random");
        end

        // R10 reversed stream in both modes
        randomize_ref(0); load_all();
        rev_test(1'b0);
        rev_test(1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule